// File: doc/BRIEF.md
# Reconfigurable-Region Isolation Controller

This block sits between the static part of a chip and a region whose logic can be reloaded while the rest keeps running. Software drives it through a small word-addressed register port. On command it stops forwarding new requests into the region and waits for the transactions already issued to be acknowledged. It then reports that the region is isolated. Once the region is isolated, software may hold the region in reset through the same control word. A second command lifts the isolation. After a programmable settling delay the block reports that traffic flows again.

Requests that arrive from the static side while the path is closed are never forwarded. Once nothing is outstanding, such a request is accepted locally and answered one cycle later with an error response, so the requester cannot stall. The event is recorded in a sticky flag that software clears by writing a one.

Register map (byte address): 0 status, 4 control, 8 illegal-access flag, 12 version. All other addresses read as zero. Writes to status, version and unmapped addresses are dropped.

Top module: `pr_isolation_ctrl`

## Requirements
- R1: After reset, status reads 2 (bit 1 set), the control word reads 0 and the illegal flag reads 0. `rgn_freeze` and `rgn_rst` are low.
- R2: Address 12 always reads the VERSION parameter (default 2). A write to it changes nothing.
- R3: While control bit 0 is set, no new downstream request is issued. Status bit 0 (isolation done) rises only once the outstanding count is zero. Status bits 0 and 1 are never set together, and `rgn_freeze` is high from the first cycle the bridge leaves the running state.
- R4: Clearing control bit 0 before isolation completes returns the bridge to running (status 2) on the next cycle.
- R5: `rgn_rst` is high exactly when status bit 0 is set and control bit 1 is set.
- R6: Setting control bit 2 while isolated clears both status bits for THAW_CYCLES cycles. After that, status reads 2.
- R7: An isolation request while already isolated has no effect, and a release request while running has no effect. In both cases status is unchanged.
- R8: A request arriving while the path is closed and nothing is outstanding is granted locally and is not forwarded. One cycle later `up_done` and `up_err` are both high, and illegal-flag bit 0 is set.
- R9: Illegal-flag bit 0 is sticky. Writing a word with bit 0 set to address 8 clears it, and writing 0 does nothing. If a capture and a clear fall in the same cycle, the flag stays set.
- R10: While running, `dn_req` follows `up_req` and `up_gnt` follows `dn_gnt`, as long as fewer than 2^OUTS_W-1 transactions are outstanding. `up_done` follows `dn_done`, and `up_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | ADDR_W | Register byte address |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | DATA_W | Register write data |
| csr_rdata | output | DATA_W | Register read data (combinational on address) |
| up_req | input | 1 | Request from static side |
| up_gnt | output | 1 | Request accepted |
| up_done | output | 1 | Response to static side |
| up_err | output | 1 | Response carries an error |
| dn_req | output | 1 | Request into region |
| dn_gnt | input | 1 | Region accepts request |
| dn_done | input | 1 | Region completes a transaction |
| rgn_freeze | output | 1 | Region is isolated or in transition |
| rgn_rst | output | 1 | Reset into the region |

## Verification
Two pairs of events can land in the same cycle. The first pair is a locally captured illegal request and a software write that clears the illegal flag. The bench forces both into one clock edge, expects the flag to read 1 afterwards, and then clears it on a quiet cycle. The second pair is the last drained acknowledge and the isolation-done decision. The bench issues a fixed backlog, releases acknowledges at random, and compares status against a behavioural reference on every clock, so a done bit that appears one cycle early is caught.

// File: rtl/pr_iso_pkg.sv
package pr_iso_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_DRAIN  = 2'd1,
      ST_FROZEN = 2'd2,
      ST_THAW   = 2'd3
   } iso_state_e;

   localparam int unsigned OFS_STATUS = 0;
   localparam int unsigned OFS_CTRL   = 4;
   localparam int unsigned OFS_ILL    = 8;
   localparam int unsigned OFS_VER    = 12;

   localparam int unsigned CB_FREEZE  = 0;
   localparam int unsigned CB_RESET   = 1;
   localparam int unsigned CB_THAW    = 2;

   localparam int unsigned SB_FRZ     = 0;
   localparam int unsigned SB_UNF     = 1;

endpackage

// File: rtl/pr_iso_csr.sv
module pr_iso_csr
   import pr_iso_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter logic [31:0] VERSION = 32'h0000_0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              frz_done,
   input  logic              unf_done,
   input  logic              ill_set,
   output logic              ctrl_freeze,
   output logic              ctrl_reset,
   output logic              ctrl_thaw,
   output logic              ill_flag
);

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_ILL    = ADDR_W'(OFS_ILL);
   localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'(OFS_VER);

   initial begin
      assert (ADDR_W >= 4) else $error("address too narrow for map");
      assert (DATA_W >= 32) else $error("data port narrower than version word");
      assert (VERSION == 32'h0000_0002 || VERSION == 32'hAD00_0003)
         else $error("unsupported version constant");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic              ill_q;
   logic              hit_ctrl;
   logic              hit_clr;

   assign hit_ctrl = wr && (addr == A_CTRL);
   assign hit_clr  = wr && (addr == A_ILL) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (hit_ctrl) begin
         ctrl_q <= wdata;
      end
   end

   // capture wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ill_q <= 1'b0;
      end else if (ill_set) begin
         ill_q <= 1'b1;
      end else if (hit_clr) begin
         ill_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_STATUS: begin
            rdata[SB_FRZ] = frz_done;
            rdata[SB_UNF] = unf_done;
         end
         A_CTRL:  rdata = ctrl_q;
         A_ILL:   rdata[0] = ill_q;
         A_VER:   rdata = DATA_W'(VERSION);
         default: rdata = '0;
      endcase
   end

   assign ctrl_freeze = ctrl_q[CB_FREEZE];
   assign ctrl_reset  = ctrl_q[CB_RESET];
   assign ctrl_thaw   = ctrl_q[CB_THAW];
   assign ill_flag    = ill_q;

   AST_ILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ill_q && !hit_clr) |=> ill_q); // R9

   AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ill_set |=> ill_q); // R9

endmodule

// File: rtl/pr_iso_fsm.sv
module pr_iso_fsm
   import pr_iso_pkg::*;
#(
   parameter int unsigned OUTS_W      = 4,
   parameter int unsigned THAW_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_freeze,
   input  logic req_thaw,
   input  logic issue,
   input  logic retire,
   output logic frz_done,
   output logic unf_done,
   output logic region_frozen,
   output logic block,
   output logic idle,
   output logic room
);

   localparam bit          HAS_THAW = (THAW_CYCLES != 0);
   localparam int unsigned CW       = (THAW_CYCLES > 1) ? $clog2(THAW_CYCLES) : 1;

   initial begin
      assert (OUTS_W >= 1) else $error("outstanding counter needs a bit");
   end

   iso_state_e        state_q, state_d;
   logic [OUTS_W-1:0] outs_q;
   logic              thaw_last;

   // outstanding-transaction tracker
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outs_q <= '0;
      end else begin
         outs_q <= outs_q + OUTS_W'(issue) - OUTS_W'(retire);
      end
   end

   assign idle = (outs_q == '0);
   assign room = (outs_q != '1);

   generate
      if (HAS_THAW) begin : g_thaw_cnt
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (state_q == ST_FROZEN && req_thaw) begin
               cnt_q <= CW'(THAW_CYCLES - 1);
            end else if (state_q == ST_THAW && cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign thaw_last = (cnt_q == '0);
      end else begin : g_thaw_none
         assign thaw_last = 1'b1;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:    if (req_freeze) state_d = ST_DRAIN;
         ST_DRAIN: begin
            if (!req_freeze)  state_d = ST_RUN;
            else if (idle)    state_d = ST_FROZEN;
         end
         ST_FROZEN: if (req_thaw) state_d = HAS_THAW ? ST_THAW : ST_RUN;
         ST_THAW:   if (thaw_last) state_d = ST_RUN;
         default:   state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
      end else begin
         state_q <= state_d;
      end
   end

   assign frz_done      = (state_q == ST_FROZEN);
   assign unf_done      = (state_q == ST_RUN);
   assign region_frozen = (state_q != ST_RUN);
   assign block         = region_frozen || req_freeze;

   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(frz_done && unf_done)); // R3

   AST_FRZ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frz_done) |-> $past(outs_q) == '0); // R3

   AST_FROZEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      frz_done |-> idle); // R3

endmodule

// File: rtl/pr_iso_gate.sv
module pr_iso_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic up_req,
   input  logic dn_gnt,
   input  logic dn_done,
   input  logic block,
   input  logic idle,
   input  logic room,
   output logic up_gnt,
   output logic up_done,
   output logic up_err,
   output logic dn_req,
   output logic issue,
   output logic ill_hit
);

   logic err_q;

   assign ill_hit = block && up_req && idle;
   assign dn_req  = up_req && !block && room;
   assign issue   = dn_req && dn_gnt;
   assign up_gnt  = block ? ill_hit : (dn_gnt && room);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else begin
         err_q <= ill_hit;
      end
   end

   assign up_done = dn_done || err_q;
   assign up_err  = err_q;

   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      up_err |-> $past(up_gnt && up_req && !dn_req)); // R8

   AST_ERR_NOT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      up_err |-> !dn_done); // R8

endmodule

// File: rtl/pr_isolation_ctrl.sv
module pr_isolation_ctrl
   import pr_iso_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned OUTS_W      = 4,
   parameter int unsigned THAW_CYCLES = 4,
   parameter logic [31:0] VERSION     = 32'h0000_0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_wr,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   input  logic              up_req,
   output logic              up_gnt,
   output logic              up_done,
   output logic              up_err,
   output logic              dn_req,
   input  logic              dn_gnt,
   input  logic              dn_done,
   output logic              rgn_freeze,
   output logic              rgn_rst
);

   logic frz_done, unf_done;
   logic c_freeze, c_reset, c_thaw, ill_flag;
   logic block, idle, room, issue, ill_hit;

   pr_iso_csr #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .VERSION(VERSION)
   ) i_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (csr_addr),
      .wr         (csr_wr),
      .wdata      (csr_wdata),
      .rdata      (csr_rdata),
      .frz_done   (frz_done),
      .unf_done   (unf_done),
      .ill_set    (ill_hit),
      .ctrl_freeze(c_freeze),
      .ctrl_reset (c_reset),
      .ctrl_thaw  (c_thaw),
      .ill_flag   (ill_flag)
   );

   pr_iso_fsm #(
      .OUTS_W     (OUTS_W),
      .THAW_CYCLES(THAW_CYCLES)
   ) i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_freeze   (c_freeze),
      .req_thaw     (c_thaw),
      .issue        (issue),
      .retire       (dn_done),
      .frz_done     (frz_done),
      .unf_done     (unf_done),
      .region_frozen(rgn_freeze),
      .block        (block),
      .idle         (idle),
      .room         (room)
   );

   pr_iso_gate i_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .up_req (up_req),
      .dn_gnt (dn_gnt),
      .dn_done(dn_done),
      .block  (block),
      .idle   (idle),
      .room   (room),
      .up_gnt (up_gnt),
      .up_done(up_done),
      .up_err (up_err),
      .dn_req (dn_req),
      .issue  (issue),
      .ill_hit(ill_hit)
   );

   assign rgn_rst = frz_done && c_reset;

   AST_RST_ONLY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_rst |-> frz_done); // R5

   AST_NO_FWD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_freeze |-> !dn_req); // R3

   AST_FLAG_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      up_err |-> ill_flag); // R8

endmodule

// File: tb/test_pr_isolation_ctrl.sv
module test_pr_isolation_ctrl;

   localparam int THAW = 4;
   localparam logic [31:0] VER = 32'h0000_0002;
   localparam int MAXO = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  csr_addr = '0;
   logic        csr_wr = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        up_req = 1'b0, dn_gnt = 1'b0, dn_done = 1'b0;
   logic        up_gnt, up_done, up_err, dn_req, rgn_freeze, rgn_rst;

   always #10 clk = ~clk;   // 50 MHz

   pr_isolation_ctrl #(.THAW_CYCLES(THAW), .VERSION(VER)) i_pr_isolation_ctrl (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .up_req(up_req),
      .up_gnt(up_gnt), .up_done(up_done), .up_err(up_err), .dn_req(dn_req),
      .dn_gnt(dn_gnt), .dn_done(dn_done), .rgn_freeze(rgn_freeze), .rgn_rst(rgn_rst));

   int checks = 0, errors = 0, cyc = 0;
   bit cmp_on = 0;

   // behavioural reference: 0 running, 1 draining, 2 isolated, 3 settling
   int          m_st = 0, m_outs = 0, m_thaw = 0;
   logic [31:0] m_ctrl = '0;
   bit          m_ill = 0, m_err = 0;

   int          t_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit blk();
      return (m_st != 0) || m_ctrl[0];
   endfunction

   // reference update
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_outs = 0; m_thaw = 0; m_ctrl = '0; m_ill = 0; m_err = 0;
      end else begin
         bit acc, iss;
         int st_n;
         acc = blk() && up_req && (m_outs == 0);
         iss = up_req && !blk() && (m_outs < MAXO) && dn_gnt;
         st_n = m_st;
         case (m_st)
            0: if (m_ctrl[0]) st_n = 1;
            1: if (!m_ctrl[0]) st_n = 0; else if (m_outs == 0) st_n = 2;
            2: if (m_ctrl[2]) begin st_n = 3; m_thaw = THAW - 1; end
            default: if (m_thaw == 0) st_n = 0; else m_thaw = m_thaw - 1;
         endcase
         m_st = st_n;
         m_outs = m_outs + int'(iss) - int'(dn_done);
         if (acc) m_ill = 1;
         else if (csr_wr && csr_addr == 4'd8 && csr_wdata[0]) m_ill = 0;
         if (csr_wr && csr_addr == 4'd4) m_ctrl = csr_wdata;
         m_err = acc;
      end
   end

   // region / requester stimulus
   always @(posedge clk) begin
      #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (t_mode)
         1: begin up_req = lfsr[0]; dn_gnt = lfsr[3]; dn_done = lfsr[5] && (m_outs > 0); end
         2: begin up_req = 1'b1; dn_gnt = 1'b1; dn_done = 1'b0; end
         3: begin up_req = 1'b1; dn_gnt = 1'b0; dn_done = 1'b0; end
         4: begin up_req = 1'b0; dn_gnt = 1'b0; dn_done = lfsr[2] && (m_outs > 0); end
         default: begin up_req = 1'b0; dn_gnt = 1'b0; dn_done = 1'b0; end
      endcase
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (cmp_on) begin
         bit b, rm, idl;
         logic [31:0] er;
         b = blk(); rm = (m_outs < MAXO); idl = (m_outs == 0);
         chk("R10", "dn_req", dn_req, up_req && !b && rm);
         chk("R8", "up_gnt", up_gnt, b ? (up_req && idl) : (dn_gnt && rm));
         chk("R10", "up_done", up_done, dn_done || m_err);
         chk("R8", "up_err", up_err, m_err);
         chk("R5", "rgn_rst", rgn_rst, (m_st == 2) && m_ctrl[1]);
         chk("R3", "rgn_freeze", rgn_freeze, m_st != 0);
         case (csr_addr)
            4'd0:  er = {30'd0, m_st == 0, m_st == 2};
            4'd4:  er = m_ctrl;
            4'd8:  er = {31'd0, m_ill};
            4'd12: er = VER;
            default: er = '0;
         endcase
         chk("R3", "csr_rdata", csr_rdata, er);
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
      @(posedge clk); #2;
      csr_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      @(posedge clk); #2;
      csr_addr = a;
      @(negedge clk);
      v = csr_rdata;
   endtask

   task automatic setmode(input int m);
      @(posedge clk); #1;
      t_mode = m;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      int zeros, n;
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;
      cmp_on = 1;

      // R1 reset state
      rd(4'd0, v);  chk("R1", "status", v, 2);
      rd(4'd4, v);  chk("R1", "ctrl", v, 0);
      rd(4'd8, v);  chk("R1", "illegal", v, 0);
      chk("R1", "rgn_freeze", rgn_freeze, 0);
      chk("R1", "rgn_rst", rgn_rst, 0);

      // R2 version constant, write ignored
      rd(4'd12, v); chk("R2", "version", v, VER);
      wr(4'd12, 32'h1234_5678);
      rd(4'd12, v); chk("R2", "version after write", v, VER);

      // R10 random pass-through
      setmode(1);
      repeat (80) @(posedge clk);
      setmode(4);
      repeat (60) @(posedge clk);

      // R3 drain then isolate
      setmode(2);
      repeat (10) @(posedge clk);
      wr(4'd4, 32'h1);
      repeat (3) @(posedge clk);
      rd(4'd0, v);  chk("R3", "status while draining", v, 0);
      chk("R3", "no forward while draining", dn_req, 0);
      setmode(4);
      n = 0;
      do begin rd(4'd0, v); n++; end while (v != 1 && n < 500);
      chk("R3", "isolation done", v, 1);
      setmode(0);

      // R5 region reset only while isolated
      chk("R5", "rgn_rst before request", rgn_rst, 0);
      wr(4'd4, 32'h2);
      @(negedge clk);
      chk("R5", "rgn_rst when isolated", rgn_rst, 1);

      // R8 illegal request while isolated
      setmode(3);
      @(negedge clk);
      chk("R8", "local grant", up_gnt, 1);
      chk("R8", "not forwarded", dn_req, 0);
      setmode(0);
      @(negedge clk);
      chk("R8", "error done", up_done, 1);
      chk("R8", "error flag", up_err, 1);
      rd(4'd8, v);  chk("R8", "illegal set", v, 1);

      // R9 write-one-to-clear
      wr(4'd8, 32'h0);
      rd(4'd8, v);  chk("R9", "write 0 keeps flag", v, 1);
      wr(4'd8, 32'h1);
      rd(4'd8, v);  chk("R9", "write 1 clears", v, 0);
      // capture and clear in the same cycle
      @(posedge clk); #1 t_mode = 3;
      #1 csr_addr = 4'd8; csr_wdata = 32'h1; csr_wr = 1'b1;
      @(posedge clk); #1 t_mode = 0;
      #1 csr_wr = 1'b0;
      rd(4'd8, v);  chk("R9", "capture beats clear", v, 1);
      wr(4'd8, 32'h1);
      rd(4'd8, v);  chk("R9", "cleared on quiet cycle", v, 0);

      // R7 isolate while isolated
      wr(4'd4, 32'h1);
      repeat (5) @(posedge clk);
      rd(4'd0, v);  chk("R7", "status stays isolated", v, 1);

      // R6 release with settling delay
      wr(4'd4, 32'h0);
      wr(4'd4, 32'h4);
      csr_addr = 4'd0;
      zeros = 0; n = 0;
      @(negedge clk);
      chk("R6", "still isolated at write", csr_rdata, 1);
      do begin
         @(negedge clk);
         if (csr_rdata == 0) zeros++;
         n++;
      end while (csr_rdata != 2 && n < 20);
      chk("R6", "settling cycles", zeros, THAW);
      chk("R6", "running again", csr_rdata, 2);
      wr(4'd4, 32'h0);

      // R7 release while running
      wr(4'd4, 32'h4);
      repeat (6) @(posedge clk);
      rd(4'd0, v);  chk("R7", "status stays running", v, 2);
      chk("R7", "no isolation", rgn_freeze, 0);
      wr(4'd4, 32'h0);

      // R4 abandon a drain
      setmode(2);
      repeat (5) @(posedge clk);
      wr(4'd4, 32'h1);
      setmode(0);
      repeat (3) @(posedge clk);
      rd(4'd0, v);  chk("R4", "draining", v, 0);
      wr(4'd4, 32'h0);
      rd(4'd0, v);  chk("R4", "abandoned to running", v, 2);
      chk("R4", "isolation off", rgn_freeze, 0);
      setmode(4);
      repeat (60) @(posedge clk);
      setmode(1);
      repeat (60) @(posedge clk);
      setmode(0);
      repeat (5) @(posedge clk);
      finish_run();
   end

endmodule